// File: doc/BRIEF.md
# Write-Protection Controller for a 16K-Byte Serial Memory

This block holds the protection state of a 16K-byte serial nonvolatile memory and decides, for every write the bus engine sees, whether that write may go ahead. It keeps two volatile enable latches (an arm latch and a register-unlock latch) and three persistent bits (a hardware-lock enable and a two-bit block selector). It also samples a board-level guard pin. The persistent bits are ordinary flops that reset does not clear, standing in for nonvolatile cells.

The bus engine hands over every data byte addressed to the top address (3FFFh of the 14-bit space, the protection register) through `reg_wr_valid` / `reg_wr_data`. It then signals how the transfer ended with `bus_stop` or `bus_start`. A captured byte is applied only when a stop follows it; a start throws it away. The three persistent bits can only change through a fixed order: arm, then unlock, then a commit byte. The commit also needs the guard pin low or the hardware-lock enable clear. For array writes, the block answers combinationally from `chk_addr`. `arr_ack` says whether the data byte is acknowledged. `arr_commit` says whether a real write cycle may start.

The sequencer has two named states. `ST_IDLE`: no byte is waiting. `ST_PEND`: a legal byte is held. Transitions:
- `ST_IDLE`→`ST_PEND` on a legal register byte.
- `ST_PEND`→`ST_IDLE` on stop, which applies the byte.
- `ST_PEND`→`ST_IDLE` on start, which discards the byte.
- `ST_PEND`→`ST_PEND` when a new legal byte replaces the held one.

Top module: `protect_ctrl`

## Requirements
- R1: After reset the arm latch and unlock latch read 0. `rd_byte` has this layout: bit7 hardware-lock enable, bits4:3 block selector, bit2 unlock, bit1 arm. Bits 6, 5 and 0 always read 0.
- R2: A register byte with bit 6, 5 or 0 set is ignored and never applied.
- R3: A stopped byte 00h clears arm and 02h sets arm, but only while unlock is 0. Neither starts a persistent cycle.
- R4: A stopped byte 06h sets unlock only while arm is 1 and unlock is 0. With arm 0 it has no effect.
- R5: While unlock is 1, a stopped byte with bit2=0 and bit1=1 (commit) does four things. It loads the enable from bit7 and the selector from bits4:3. It clears unlock. It leaves arm set. It pulses `nv_cycle` for one cycle, starting the cycle after the stop.
- R6: While unlock is 1, a stopped byte with bit2=1 or bit1=0 changes nothing; unlock and arm stay 1.
- R7: A start instead of a stop after a register byte discards it; no latch or persistent bit changes.
- R8: `arr_nv_start` clears unlock from the next cycle.
- R9: While the guard pin and the enable are both 1, a commit is refused. The persistent bits stay unchanged, no `nv_cycle` pulse is given, and unlock stays 1. The enable therefore cannot be lowered in this condition.
- R10: Selector 00 protects nothing. Selector 01 protects 3000h–3FFFh. Selector 10 protects 2000h–3FFFh. Selector 11 protects all addresses.
- R11: `arr_ack` equals the arm latch, and `arr_commit` is arm AND not protected. Both are combinational from `chk_addr` and the state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (volatile state only) |
| reg_wr_valid | input | 1 | Data byte for the protection register received |
| reg_wr_data | input | 8 | That data byte |
| bus_start | input | 1 | Start condition seen (pulse) |
| bus_stop | input | 1 | Stop condition seen (pulse) |
| arr_nv_start | input | 1 | Array persistent write cycle started (pulse) |
| guard_pin | input | 1 | Board hardware-protect pin |
| chk_addr | input | 14 | Array address of the write being decided |
| arr_ack | output | 1 | Acknowledge the array data byte |
| arr_commit | output | 1 | Array write may start a cycle |
| nv_cycle | output | 1 | Register write started a persistent cycle |
| rd_byte | output | 8 | Register readback |

## Verification
The bench goes after the sequence edges:
- A 00h sent while unlocked. A design that lets it through would clear arm and leave unlock alone.
- A commit ended by a restart. A design that fails here would program the bits anyway.
- A commit under the guard pin. A wrong design would lower the enable.

It probes the selector boundaries at 1FFFh/2000h and 2FFFh/3000h, where an off-by-one decode would protect the wrong half. Bytes with reserved bits set are sent to catch a design that applies them.

// File: rtl/prot_pkg.sv
package prot_pkg;
    typedef enum logic [0:0] {ST_IDLE, ST_PEND} seq_state_t;

    typedef struct packed {
        logic       lock_en;
        logic [1:0] blk_sel;
    } nv_bits_t;

    localparam logic [7:0] RSV_MASK     = 8'h61;
    localparam logic [7:0] BYTE_DISARM  = 8'h00;
    localparam logic [7:0] BYTE_ARM     = 8'h02;
    localparam logic [7:0] BYTE_UNLOCK  = 8'h06;
    localparam int         POS_LOCK_EN  = 7;
    localparam int         POS_BLK_HI   = 4;
    localparam int         POS_BLK_LO   = 3;
    localparam int         POS_UNLOCK   = 2;
    localparam int         POS_ARM      = 1;
endpackage

// File: rtl/prot_seq.sv
module prot_seq
    import prot_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_valid,
    input  logic [DATA_W-1:0] reg_wr_data,
    input  logic              bus_start,
    input  logic              bus_stop,
    input  logic              arr_nv_start,
    input  logic              hw_prot,
    output logic              arm_q,
    output logic              unl_q,
    output logic              nv_we,
    output nv_bits_t          nv_wdata,
    output logic              nv_cycle_q
);
    seq_state_t        state_q, state_d;
    logic [DATA_W-1:0] pend_q, pend_d;
    logic              arm_d, unl_d;
    logic              legal_byte, apply;

    assign legal_byte = reg_wr_valid && ((reg_wr_data & RSV_MASK) == '0);
    assign apply      = (state_q == ST_PEND) && bus_stop;

    // next-state process
    always_comb begin
        state_d = state_q;
        pend_d  = pend_q;
        unique case (state_q)
            ST_IDLE: begin
                if (legal_byte) begin
                    state_d = ST_PEND;
                    pend_d  = reg_wr_data;
                end
            end
            ST_PEND: begin
                if (bus_stop || bus_start) begin
                    state_d = ST_IDLE;
                end else if (legal_byte) begin
                    pend_d = reg_wr_data;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // output / latch-update process
    always_comb begin
        arm_d    = arm_q;
        unl_d    = unl_q;
        nv_we    = 1'b0;
        nv_wdata = '{lock_en: pend_q[POS_LOCK_EN],
                     blk_sel: pend_q[POS_BLK_HI:POS_BLK_LO]};
        if (apply) begin
            if (!unl_q) begin
                if (pend_q == BYTE_DISARM) begin
                    arm_d = 1'b0;
                end else if (pend_q == BYTE_ARM) begin
                    arm_d = 1'b1;
                end else if (pend_q == BYTE_UNLOCK && arm_q) begin
                    unl_d = 1'b1;
                end
            end else if (!pend_q[POS_UNLOCK] && pend_q[POS_ARM] && !hw_prot) begin
                nv_we = 1'b1;
                unl_d = 1'b0;
            end
        end
        if (arr_nv_start) begin
            unl_d = 1'b0;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            pend_q     <= '0;
            arm_q      <= 1'b0;
            unl_q      <= 1'b0;
            nv_cycle_q <= 1'b0;
        end else begin
            state_q    <= state_d;
            pend_q     <= pend_d;
            arm_q      <= arm_d;
            unl_q      <= unl_d;
            nv_cycle_q <= nv_we;
        end
    end

    // R6
    unlock_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unl_q |-> arm_q);

    // R5
    nv_cycle_after_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nv_cycle_q |-> (!unl_q && $past(unl_q)));

    // R8
    array_clears_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arr_nv_start |=> !unl_q);

    // R3
    disarm_applied_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (apply && !unl_q && pend_q == BYTE_DISARM) |=> !arm_q);
endmodule

// File: rtl/prot_nvbits.sv
module prot_nvbits
    import prot_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     nv_we,
    input  nv_bits_t nv_wdata,
    input  logic     hw_prot,
    output nv_bits_t nv_q
);
    // persistent cells: no reset by design
    always_ff @(posedge clk) begin
        if (nv_we) begin
            nv_q <= nv_wdata;
        end
    end

    // R9
    guarded_bits_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hw_prot |=> $stable(nv_q));
endmodule

// File: rtl/prot_decode.sv
module prot_decode #(
    parameter int ADDR_W = 14
) (
    input  logic [ADDR_W-1:0] chk_addr,
    input  logic [1:0]        blk_sel,
    input  logic              arm,
    output logic              arr_ack,
    output logic              arr_commit
);
    localparam int TOP = ADDR_W - 1;

    logic locked;

    always_comb begin
        unique case (blk_sel)
            2'b00: locked = 1'b0;
            2'b01: locked = chk_addr[TOP] && chk_addr[TOP-1];
            2'b10: locked = chk_addr[TOP];
            2'b11: locked = 1'b1;
            default: locked = 1'b1;
        endcase
    end

    assign arr_ack    = arm;
    assign arr_commit = arm && !locked;

    // R10
    always_comb begin
        full_lock_chk: assert (!(blk_sel == 2'b11 && arr_commit));
    end
endmodule

// File: rtl/protect_ctrl.sv
module protect_ctrl
    import prot_pkg::*;
#(
    parameter int ADDR_W = 14,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_valid,
    input  logic [DATA_W-1:0] reg_wr_data,
    input  logic              bus_start,
    input  logic              bus_stop,
    input  logic              arr_nv_start,
    input  logic              guard_pin,
    input  logic [ADDR_W-1:0] chk_addr,
    output logic              arr_ack,
    output logic              arr_commit,
    output logic              nv_cycle,
    output logic [DATA_W-1:0] rd_byte
);
    logic     arm_q, unl_q, nv_we, hw_prot;
    nv_bits_t nv_wdata, nv_q;

    assign hw_prot = guard_pin && nv_q.lock_en;

    prot_seq #(.DATA_W(DATA_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr_valid(reg_wr_valid),
        .reg_wr_data (reg_wr_data),
        .bus_start   (bus_start),
        .bus_stop    (bus_stop),
        .arr_nv_start(arr_nv_start),
        .hw_prot     (hw_prot),
        .arm_q       (arm_q),
        .unl_q       (unl_q),
        .nv_we       (nv_we),
        .nv_wdata    (nv_wdata),
        .nv_cycle_q  (nv_cycle)
    );

    prot_nvbits u_nv (
        .clk     (clk),
        .rst_n   (rst_n),
        .nv_we   (nv_we),
        .nv_wdata(nv_wdata),
        .hw_prot (hw_prot),
        .nv_q    (nv_q)
    );

    prot_decode #(.ADDR_W(ADDR_W)) u_dec (
        .chk_addr  (chk_addr),
        .blk_sel   (nv_q.blk_sel),
        .arm       (arm_q),
        .arr_ack   (arr_ack),
        .arr_commit(arr_commit)
    );

    always_comb begin
        rd_byte              = '0;
        rd_byte[POS_LOCK_EN] = nv_q.lock_en;
        rd_byte[POS_BLK_HI]  = nv_q.blk_sel[1];
        rd_byte[POS_BLK_LO]  = nv_q.blk_sel[0];
        rd_byte[POS_UNLOCK]  = unl_q;
        rd_byte[POS_ARM]     = arm_q;
    end

    // R9
    no_commit_when_guarded_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hw_prot |=> !nv_cycle);
endmodule

// File: tb/test_protect_ctrl.sv
module test_protect_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_valid = 1'b0;
    logic [7:0]  reg_wr_data = '0;
    logic        bus_start = 1'b0;
    logic        bus_stop = 1'b0;
    logic        arr_nv_start = 1'b0;
    logic        guard_pin = 1'b0;
    logic [13:0] chk_addr = '0;
    logic        arr_ack, arr_commit, nv_cycle;
    logic [7:0]  rd_byte;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 0;

    bit       m_arm, m_unl, m_len, m_nv;
    bit [1:0] m_blk;

    always #2 clk = ~clk;

    protect_ctrl i_protect_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr_valid(reg_wr_valid),
        .reg_wr_data(reg_wr_data), .bus_start(bus_start), .bus_stop(bus_stop),
        .arr_nv_start(arr_nv_start), .guard_pin(guard_pin), .chk_addr(chk_addr),
        .arr_ack(arr_ack), .arr_commit(arr_commit), .nv_cycle(nv_cycle),
        .rd_byte(rd_byte)
    );

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    function automatic bit [7:0] exp_rd();
        return {m_len, 2'b00, m_blk, m_unl, m_arm, 1'b0};
    endfunction

    function automatic bit exp_locked(bit [13:0] a, bit [1:0] b);
        case (b)
            2'd0: return 1'b0;
            2'd1: return a >= 14'h3000;
            2'd2: return a >= 14'h2000;
            default: return 1'b1;
        endcase
    endfunction

    function automatic void model_stop(bit [7:0] d, bit pin);
        m_nv = 1'b0;
        if ((d & 8'h61) != 0) return;
        if (!m_unl) begin
            if (d == 8'h00) m_arm = 1'b0;
            else if (d == 8'h02) m_arm = 1'b1;
            else if (d == 8'h06 && m_arm) m_unl = 1'b1;
        end else if (!d[2] && d[1] && !(pin && m_len)) begin
            m_len = d[7];
            m_blk = d[4:3];
            m_unl = 1'b0;
            m_nv  = 1'b1;
        end
    endfunction

    task automatic xfer(bit [7:0] d, bit use_stop, string tag);
        @(negedge clk);
        reg_wr_valid = 1'b1;
        reg_wr_data  = d;
        @(negedge clk);
        reg_wr_valid = 1'b0;
        if (use_stop) bus_stop = 1'b1; else bus_start = 1'b1;
        @(negedge clk);
        bus_stop  = 1'b0;
        bus_start = 1'b0;
        if (use_stop) model_stop(d, guard_pin); else m_nv = 1'b0;
        check({tag, " nv_cycle"}, nv_cycle, m_nv);
        check({tag, " rd_byte"}, rd_byte, exp_rd());
        @(negedge clk);
        check({tag, " nv_cycle end"}, nv_cycle, 1'b0);
    endtask

    task automatic probe(bit [13:0] a, string tag);
        chk_addr = a;
        #1;
        check({tag, " arr_ack"}, arr_ack, m_arm);
        check({tag, " arr_commit"}, arr_commit, m_arm && !exp_locked(a, m_blk));
    endtask

    task automatic pulse_array(string tag);
        @(negedge clk);
        arr_nv_start = 1'b1;
        @(negedge clk);
        arr_nv_start = 1'b0;
        m_unl = 1'b0;
        check({tag, " rd_byte"}, rd_byte, exp_rd());
    endtask

    task automatic finish_run();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            n_bad++;
            $display("FAIL watchdog: got %0d cycles expected below 100000", cyc);
            finish_run();
        end
    end

    initial begin
        int seed = 7;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state of volatile latches and reserved bits
        check("R1 reset latches/reserved", rd_byte & 8'h67, 8'h00);
        check("R11 reset arr_ack", arr_ack, 1'b0);

        // bring persistent bits to a known value (R5 commit of zeros)
        xfer(8'h02, 1, "R3 arm");
        xfer(8'h06, 1, "R4 unlock");
        m_len = rd_byte[7]; m_blk = rd_byte[4:3];
        xfer(8'h02, 1, "R5 commit zeros");
        check("R5 bits cleared", rd_byte, 8'h02);

        // R2 reserved bits set
        xfer(8'h01, 1, "R2 bit0");
        xfer(8'h20, 1, "R2 bit5");
        xfer(8'h40, 1, "R2 bit6");
        xfer(8'h61, 1, "R2 all reserved");

        // R3 disarm / arm without persistent cycle
        xfer(8'h00, 1, "R3 disarm");
        probe(14'h0010, "R11 disarmed");
        // R4 unlock refused while disarmed
        xfer(8'h06, 1, "R4 unlock without arm");
        xfer(8'h02, 1, "R3 rearm");
        xfer(8'h06, 1, "R4 unlock");

        // R6 non-commit bytes in step 3
        xfer(8'h06, 1, "R6 unlock bit set");
        xfer(8'h00, 1, "R6 disarm refused");
        check("R6 still unlocked", rd_byte, 8'h06);

        // R7 restart discards commit
        xfer(8'h9A, 0, "R7 start abort");
        check("R7 state kept", rd_byte, 8'h06);

        // R5 commit selector 10, R10 boundaries
        xfer(8'h12, 1, "R5 commit half");
        probe(14'h1FFF, "R10 half below");
        probe(14'h2000, "R10 half edge");
        probe(14'h3FFF, "R10 half top");
        xfer(8'h06, 1, "R4 unlock");
        xfer(8'h0A, 1, "R5 commit quarter");
        probe(14'h2FFF, "R10 quarter below");
        probe(14'h3000, "R10 quarter edge");
        xfer(8'h06, 1, "R4 unlock");
        xfer(8'h1A, 1, "R5 commit full");
        probe(14'h0000, "R10 full bottom");
        xfer(8'h06, 1, "R4 unlock");
        xfer(8'h02, 1, "R5 commit none");
        probe(14'h3FFF, "R10 none top");

        // R8 array write clears unlock
        xfer(8'h06, 1, "R4 unlock");
        pulse_array("R8 array cycle");
        check("R8 unlock cleared", rd_byte[2], 1'b0);

        // R9 guard pin with enable set
        xfer(8'h06, 1, "R4 unlock");
        xfer(8'h82, 1, "R5 set enable");
        guard_pin = 1'b1;
        xfer(8'h06, 1, "R4 unlock guarded");
        xfer(8'h1A, 1, "R9 guarded commit");
        xfer(8'h02, 1, "R9 lower enable refused");
        check("R9 enable kept", rd_byte, 8'h86);
        guard_pin = 1'b0;
        xfer(8'h02, 1, "R9 unguarded commit");
        check("R9 enable lowered", rd_byte, 8'h02);

        // constrained random traffic
        for (int i = 0; i < 400; i++) begin
            bit [7:0] d;
            int sel = $urandom_range(0, 6);
            case (sel)
                0: d = 8'h00;
                1: d = 8'h02;
                2, 3: d = 8'h06;
                4: d = {$urandom_range(0, 1) == 1, 2'b00, 2'($urandom_range(0, 3)),
                        3'b010};
                5: d = {$urandom_range(0, 1) == 1, 2'b00, 2'($urandom_range(0, 3)),
                        1'b1, 1'b1, 1'b0};
                default: d = 8'($urandom_range(0, 255));
            endcase
            guard_pin = ($urandom_range(0, 3) == 0);
            xfer(d, $urandom_range(0, 4) != 0, "R5/R6/R7/R9 random");
            if ($urandom_range(0, 9) == 0) pulse_array("R8 random");
            probe(14'($urandom_range(0, 16383)), "R10/R11 random");
        end
        finish_run();
    end
endmodule